// File: doc/BRIEF.md
# Token-Bus Transmit Buffer Streamer

A host writes a packet into one 512-byte page of local RAM and then issues an enable-transmit command that names the page. The block waits for a token-grant pulse. It then reads the destination byte and the count bytes from the page and works out whether the packet is short or long. After that it plays the whole frame out, one byte at a time, on a valid/ready stream that feeds a line encoder. The source-ID slot is always filled from the node-ID input and never from RAM.

A count byte holds the number of data bytes subtracted from the page end, so its value is also the offset of the first data byte. Short packets end at offset 255 and long packets at offset 511. A zero in the first count byte, with long packets enabled, marks the long format, and the second count byte then applies. Two status outputs report progress. One is a transmit-available flag. The other is an acknowledged flag that is never set for broadcasts. A maskable interrupt level follows transmit-available.

Top module: `tbus_tx_streamer`

## Requirements
- R1: After reset, tx_avail is 1, tx_acked is 0, tx_valid is 0 and ram_rd_en is 0.
- R2: A cmd_valid pulse while tx_avail is 1 latches cmd_page and clears tx_avail and tx_acked on the next cycle. A cmd_valid while tx_avail is 0 is ignored: the page in use, the stream and the flags are unchanged.
- R3: No RAM read and no output byte occur between command acceptance and a token_grant pulse. A token_grant while tx_avail is 1 starts nothing.
- R4: The RAM address is cmd_page*512 + offset. The frame is: node_id (the byte at offset 0 is discarded), then the byte at offset 1 (destination), then the byte at offset 2, then the byte at offset 3 for long packets only, then the data bytes in ascending offset order. tx_last is 1 on the final byte only.
- R5: If offset 2 is non-zero, or long_en is 0, the packet is short and its data runs from offset (value at offset 2) to offset 255.
- R6: If long_en is 1 and offset 2 is zero, the packet is long and its data runs from offset (value at offset 3) to offset 511.
- R7: A short count below 3 (including zero with long_en at 0) starts the data at offset 3. A long count below 4 starts it at offset 4.
- R8: While tx_valid is 1 and tx_ready is 0, tx_data and tx_last stay stable. Every byte is delivered exactly once. With tx_ready held at 1, the bytes of a frame leave on consecutive cycles.
- R9: tx_avail returns to 1 on the cycle after the handshake of the tx_last byte, and no further byte follows.
- R10: On completion, tx_acked becomes 1 if ack_in was 1 in some cycle from acceptance through the final handshake and the destination byte is non-zero. A destination of 0 (broadcast) leaves it at 0.
- R11: irq equals tx_avail AND irq_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | Local node ID sent in the source slot |
| long_en | input | 1 | Enables recognition of the long format |
| irq_mask | input | 1 | Completion interrupt enable |
| cmd_valid | input | 1 | Enable-transmit command strobe |
| cmd_page | input | $clog2(NUM_PAGES) | Page holding the packet |
| token_grant | input | 1 | Pulse allowing the transmission to start |
| ack_in | input | 1 | Acknowledge seen from the receiver |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_addr | output | $clog2(NUM_PAGES)+9 | RAM read address |
| ram_rd_data | input | 8 | RAM data, one cycle after the strobe |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_avail | output | 1 | Previous transmit has finished |
| tx_acked | output | 1 | Last directed packet was acknowledged |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench targets the edges of the count decoding. These are a one-byte short packet, the 257-byte long minimum, counts that would overlap the header, and a zero first count with long packets disabled. A wrong decoder would send header bytes as data, read past the page end, or pick the wrong end offset. A command issued mid-transmission to another page must leave the stream unchanged, so a design that re-latched the page would switch data mid-frame. Random back-pressure exposes any dropped or repeated byte around the one-cycle RAM latency, while a ready-always run exposes throughput bubbles. A broadcast packet sent together with an acknowledge catches a flag that ignores the destination.

// File: rtl/tbx_pkg.sv
package tbx_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 9;   // a page spans 512 bytes

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;

    // offsets that the frame layout fixes
    localparam off_t OFF_DID   = 9'd1;
    localparam off_t OFF_CNT0  = 9'd2;
    localparam off_t OFF_CNT1  = 9'd3;
    localparam off_t END_SHORT = 9'd255;
    localparam off_t END_LONG  = 9'd511;
    localparam off_t MIN_SHORT = 9'd3;
    localparam off_t MIN_LONG  = 9'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HDR_DID,
        ST_HDR_C0,
        ST_HDR_C1,
        ST_STREAM
    } st_e;

    // attributes travelling with a RAM read
    typedef struct packed {
        logic sid;
        logic last;
    } rtag_t;

    // one queued output byte
    typedef struct packed {
        logic  last;
        byte_t data;
    } item_t;

    // layout of the frame in the page
    typedef struct packed {
        off_t hdr_end;
        off_t first;
        off_t last;
    } fmt_t;

    function automatic off_t clamp_up(byte_t cnt, off_t floor_v);
        off_t w;
        w = {1'b0, cnt};
        return (w < floor_v) ? floor_v : w;
    endfunction

    function automatic fmt_t decode_fmt(byte_t c0, byte_t c1, logic long_ok);
        fmt_t f;
        if (long_ok && (c0 == '0)) begin
            f.hdr_end = OFF_CNT1;
            f.first   = clamp_up(c1, MIN_LONG);
            f.last    = END_LONG;
        end else begin
            f.hdr_end = OFF_CNT0;
            f.first   = clamp_up(c0, MIN_SHORT);
            f.last    = END_SHORT;
        end
        return f;
    endfunction

endpackage

// File: rtl/tbx_hdr_capture.sv
module tbx_hdr_capture
    import tbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_did,
    input  logic  cap_c0,
    input  logic  cap_c1,
    input  logic  long_en,
    input  byte_t rdata,
    output byte_t did,
    output fmt_t  fmt
);
    byte_t c0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            did  <= '0;
            c0_q <= '0;
            fmt  <= '0;
        end else begin
            if (cap_did) did  <= rdata;
            if (cap_c0)  c0_q <= rdata;
            if (cap_c1)  fmt  <= decode_fmt(c0_q, rdata, long_en);
        end
    end

    // R5 R6: the decoded data window always ends on a page-half boundary
    assert_fmt_end_R6: assert property (@(posedge clk) disable iff (rst)
        $past(cap_c1) |-> (fmt.last == END_SHORT || fmt.last == END_LONG));

    // R7: the data never starts inside the header
    assert_fmt_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        $past(cap_c1) |-> (fmt.first > fmt.hdr_end));

endmodule

// File: rtl/tbx_addr_seq.sv
module tbx_addr_seq
    import tbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    input  fmt_t fmt,
    output off_t off,
    output logic busy,
    output logic at_last,
    output logic at_sid
);
    assign at_last = (off == fmt.last);
    assign at_sid  = (off == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            off  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            off  <= '0;
            busy <= 1'b1;
        end else if (step && busy) begin
            if (at_last) begin
                busy <= 1'b0;
            end else if (off == fmt.hdr_end) begin
                off <= fmt.first;
            end else begin
                off <= off + 1'b1;
            end
        end
    end

    // R4: reads are only requested while a frame is being walked
    assert_step_busy_R4: assert property (@(posedge clk) disable iff (rst)
        step |-> busy);

    // R4: the walk never passes the end of the frame
    assert_off_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (off <= fmt.last));

endmodule

// File: rtl/tbx_out_fifo.sv
module tbx_out_fifo
    import tbx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  item_t                      push_item,
    input  logic                       pop,
    output item_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    item_t            slot_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;

    assign empty = (cnt == '0);
    assign head  = slot_q[rp_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
            cnt  <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (push) begin
                slot_q[wp_q] <= push_item;
                wp_q         <= (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
            end
            if (pop) begin
                rp_q <= (rp_q == PTR_MAX) ? '0 : rp_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8: the read credit scheme must never overfill the queue
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (int'(cnt) < DEPTH));

    // R8: nothing is taken from an empty queue
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/tbus_tx_streamer.sv
module tbus_tx_streamer
    import tbx_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [7:0]                         node_id,
    input  logic                               long_en,
    input  logic                               irq_mask,
    input  logic                               cmd_valid,
    input  logic [$clog2(NUM_PAGES)-1:0]       cmd_page,
    input  logic                               token_grant,
    input  logic                               ack_in,
    output logic                               ram_rd_en,
    output logic [$clog2(NUM_PAGES)+OFF_W-1:0] ram_rd_addr,
    input  logic [7:0]                         ram_rd_data,
    output logic                               tx_valid,
    output logic [7:0]                         tx_data,
    output logic                               tx_last,
    input  logic                               tx_ready,
    output logic                               tx_avail,
    output logic                               tx_acked,
    output logic                               irq
);
    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    st_e               st_q, st_d;
    logic [PAGE_W-1:0] page_q;
    logic              avail_q, acked_q, ack_seen_q;
    logic              accept, finish, pop, issue;
    logic              cap_did, cap_c0, cap_c1;
    byte_t             did;
    fmt_t              fmt;
    off_t              seq_off, rd_off;
    logic              seq_busy, seq_last, seq_sid;
    logic              inflight_q;
    rtag_t             tag_q;
    item_t             push_item, head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_empty;

    // ---------------- control ----------------
    assign accept  = cmd_valid && avail_q;
    assign cap_did = (st_q == ST_HDR_DID);
    assign cap_c0  = (st_q == ST_HDR_C0);
    assign cap_c1  = (st_q == ST_HDR_C1);
    assign pop     = tx_valid && tx_ready;
    assign finish  = pop && head.last;

    // a read may go out when queue + read in flight, after this pop, leave room
    assign issue = (st_q == ST_STREAM) && seq_busy &&
                   ((int'(fifo_cnt) + int'(inflight_q) - int'(pop)) < FIFO_DEPTH);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (accept)      st_d = ST_ARMED;
            ST_ARMED:   if (token_grant) st_d = ST_HDR_DID;
            ST_HDR_DID: st_d = ST_HDR_C0;
            ST_HDR_C0:  st_d = ST_HDR_C1;
            ST_HDR_C1:  st_d = ST_STREAM;
            ST_STREAM:  if (finish)      st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // ---------------- RAM read port ----------------
    always_comb begin
        ram_rd_en = 1'b0;
        rd_off    = seq_off;
        case (st_q)
            ST_ARMED: if (token_grant) begin
                ram_rd_en = 1'b1;
                rd_off    = OFF_DID;
            end
            ST_HDR_DID: begin
                ram_rd_en = 1'b1;
                rd_off    = OFF_CNT0;
            end
            ST_HDR_C0: begin
                ram_rd_en = 1'b1;
                rd_off    = OFF_CNT1;
            end
            ST_STREAM: ram_rd_en = issue;
            default:   ram_rd_en = 1'b0;
        endcase
    end

    assign ram_rd_addr = {page_q, rd_off};

    // ---------------- header and walk ----------------
    tbx_hdr_capture u_hdr (
        .clk     (clk),
        .rst     (rst),
        .cap_did (cap_did),
        .cap_c0  (cap_c0),
        .cap_c1  (cap_c1),
        .long_en (long_en),
        .rdata   (ram_rd_data),
        .did     (did),
        .fmt     (fmt)
    );

    tbx_addr_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (cap_c1),
        .step    (issue),
        .fmt     (fmt),
        .off     (seq_off),
        .busy    (seq_busy),
        .at_last (seq_last),
        .at_sid  (seq_sid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= 1'b0;
            tag_q      <= '0;
        end else begin
            inflight_q <= issue;
            tag_q      <= '{sid: seq_sid, last: seq_last};
        end
    end

    // the stored source slot is replaced on the way into the queue
    assign push_item = '{last: tag_q.last,
                         data: tag_q.sid ? node_id : ram_rd_data};

    tbx_out_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (inflight_q),
        .push_item (push_item),
        .pop       (pop),
        .head      (head),
        .cnt       (fifo_cnt),
        .empty     (fifo_empty)
    );

    assign tx_valid = !fifo_empty;
    assign tx_data  = head.data;
    assign tx_last  = head.last;

    // ---------------- status ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q    <= 1'b1;
            acked_q    <= 1'b0;
            ack_seen_q <= 1'b0;
            page_q     <= '0;
        end else if (accept) begin
            avail_q    <= 1'b0;
            acked_q    <= 1'b0;
            ack_seen_q <= 1'b0;
            page_q     <= cmd_page;
        end else begin
            if (ack_in && !avail_q) ack_seen_q <= 1'b1;
            if (finish) begin
                avail_q <= 1'b1;
                acked_q <= (ack_seen_q || ack_in) && (did != '0);
            end
        end
    end

    assign tx_avail = avail_q;
    assign tx_acked = acked_q;
    assign irq      = avail_q && irq_mask;

    // ---------------- assertions ----------------
    assert_accept_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && tx_avail) |=> (!tx_avail && !tx_acked));

    assert_busy_cmd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !tx_avail) |=> $stable(page_q));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        tx_avail |-> (!ram_rd_en && !tx_valid));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_avail) |-> $past(tx_valid && tx_ready && tx_last));

    assert_bcast_no_ack_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_acked) |-> (did != '0));

endmodule

// File: tb/sim_tbus_tx_streamer.sv
`timescale 1ns/1ps
module sim_tbus_tx_streamer;
    localparam int NUM_PAGES  = 4;
    localparam int PAGE_W     = 2;
    localparam int ADDR_W     = 11;
    localparam int PAGE_BYTES = 512;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst = 1'b1;
    logic [7:0]        node_id = 8'h5A;
    logic              long_en = 1'b1, irq_mask = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic              token_grant = 1'b0, ack_in = 1'b0;
    logic              ram_rd_en;
    logic [ADDR_W-1:0] ram_rd_addr;
    logic [7:0]        ram_rd_data = '0;
    logic              tx_valid, tx_last;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;
    logic              tx_avail, tx_acked, irq;

    logic [7:0] mem [NUM_PAGES*PAGE_BYTES];
    always @(posedge clk) if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];

    tbus_tx_streamer #(.NUM_PAGES(NUM_PAGES), .FIFO_DEPTH(2)) u0 (
        .clk(clk), .rst(rst), .node_id(node_id), .long_en(long_en),
        .irq_mask(irq_mask), .cmd_valid(cmd_valid), .cmd_page(cmd_page),
        .token_grant(token_grant), .ack_in(ack_in),
        .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .tx_avail(tx_avail), .tx_acked(tx_acked), .irq(irq)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard monitor ----------------
    logic [8:0]  sb [$];
    int          cyc = 0, first_hs = -1, last_hs = -1;
    bit          stall_mode = 0, rd_seen = 0, done_chk = 0, prev_stall = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  prev_data = '0;
    logic        prev_last = 1'b0;
    string       cur_req = "R4";

    always begin
        logic [8:0] exp;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
        #1;
        cyc++;
        if (ram_rd_en) rd_seen = 1;
        if (!rst) begin
            if (done_chk) begin
                check(tx_avail == 1'b1, "R9", "avail after last", int'(tx_avail), 1);
                check(tx_valid == 1'b0, "R9", "no byte after last", int'(tx_valid), 0);
                done_chk = 0;
            end
            if (prev_stall)
                check(tx_valid && tx_data == prev_data && tx_last == prev_last,
                      "R8", "byte held under stall", int'(tx_data), int'(prev_data));
            if (tx_valid && tx_ready) begin
                if (sb.size() == 0) begin
                    check(0, cur_req, "unexpected byte", int'(tx_data), -1);
                end else begin
                    exp = sb.pop_front();
                    check({tx_last, tx_data} == exp, cur_req, "stream byte {last,data}",
                          int'({tx_last, tx_data}), int'(exp));
                    if (exp[8]) begin
                        check(tx_avail == 1'b0, "R9", "busy on last byte", int'(tx_avail), 0);
                        done_chk = 1;
                    end
                end
                if (first_hs < 0) first_hs = cyc;
                last_hs = cyc;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
        end
    end

    // ---------------- driver ----------------
    task automatic run_pkt(input int page, input logic [7:0] did,
                           input logic [7:0] c0, input logic [7:0] c1,
                           input bit lng, input bit give_ack, input bit stall,
                           input bit poke_cmd, input string req);
        int base, first, lastoff, total;
        bit is_long, exp_ack;
        base = page * PAGE_BYTES;
        long_en = lng;
        stall_mode = stall;
        cur_req = req;
        mem[base]     = 8'hEE ^ 8'(page);
        mem[base + 1] = did;
        mem[base + 2] = c0;
        mem[base + 3] = c1;
        for (int i = 4; i < PAGE_BYTES; i++) mem[base + i] = 8'(i * 29 + page * 71 + c1);
        // expected frame from the requirements
        is_long = lng && (c0 == 8'd0);
        if (is_long) begin
            first = (c1 < 8'd4) ? 4 : int'(c1);
            lastoff = 511;
        end else begin
            first = (c0 < 8'd3) ? 3 : int'(c0);
            lastoff = 255;
        end
        sb.push_back({1'b0, node_id});
        sb.push_back({1'b0, did});
        sb.push_back({1'b0, c0});
        if (is_long) sb.push_back({1'b0, c1});
        for (int o = first; o <= lastoff; o++)
            sb.push_back({(o == lastoff), mem[base + o]});
        total = sb.size();
        exp_ack = give_ack && (did != 8'd0);
        first_hs = -1;

        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_page  = PAGE_W'(page);
        @(negedge clk);
        cmd_valid = 1'b0;
        rd_seen   = 0;
        check(tx_avail == 1'b0, "R2", "avail cleared by command", int'(tx_avail), 0);
        check(tx_acked == 1'b0, "R2", "acked cleared by command", int'(tx_acked), 0);
        check(irq == 1'b0, "R11", "irq low while busy", int'(irq), 0);
        repeat (6) @(negedge clk);
        check(!rd_seen && !tx_valid, "R3", "quiet before token", int'(rd_seen), 0);
        token_grant = 1'b1;
        @(negedge clk);
        token_grant = 1'b0;
        if (give_ack) begin
            repeat (2) @(negedge clk);
            ack_in = 1'b1;
            @(negedge clk);
            ack_in = 1'b0;
        end
        if (poke_cmd) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_page  = PAGE_W'(page ^ 1);
            @(negedge clk);
            cmd_valid = 1'b0;
            check(tx_avail == 1'b0, "R2", "busy command ignored", int'(tx_avail), 0);
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #2;
        check(tx_acked == exp_ack, "R10", "acked flag", int'(tx_acked), int'(exp_ack));
        check(irq == irq_mask, "R11", "irq follows mask", int'(irq), int'(irq_mask));
        check(tx_avail && !tx_valid, "R2", "no restart after frame", int'(tx_valid), 0);
        if (!stall)
            check(last_hs - first_hs == total - 1, "R8", "back-to-back bytes",
                  last_hs - first_hs, total - 1);
    endtask

    initial begin
        for (int i = 0; i < NUM_PAGES * PAGE_BYTES; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(tx_avail == 1'b1, "R1", "reset avail", int'(tx_avail), 1);
        check(tx_acked == 1'b0, "R1", "reset acked", int'(tx_acked), 0);
        check(tx_valid == 1'b0, "R1", "reset valid", int'(tx_valid), 0);
        check(ram_rd_en == 1'b0, "R1", "reset read", int'(ram_rd_en), 0);
        check(irq == 1'b1, "R11", "irq with mask set while idle", int'(irq), 1);

        // token while idle does nothing
        @(negedge clk);
        rd_seen = 0;
        token_grant = 1'b1;
        @(negedge clk);
        token_grant = 1'b0;
        repeat (5) @(negedge clk);
        check(!rd_seen && !tx_valid && tx_avail, "R3", "idle token ignored", int'(rd_seen), 0);

        run_pkt(1, 8'h22, 8'd251, 8'h00, 1, 1, 0, 0, "R4 R5 short N=5");
        run_pkt(2, 8'h31, 8'd0, 8'd212, 1, 0, 1, 1, "R4 R6 long N=300");
        node_id  = 8'hA7;
        irq_mask = 1'b0;
        run_pkt(0, 8'h00, 8'd250, 8'h10, 1, 1, 1, 0, "R10 broadcast");
        irq_mask = 1'b1;
        run_pkt(3, 8'h44, 8'd0, 8'd100, 0, 1, 0, 0, "R7 R5 zero count short");
        run_pkt(1, 8'h55, 8'd1, 8'h09, 1, 0, 0, 0, "R7 short clamp");
        run_pkt(2, 8'h66, 8'd0, 8'd2, 1, 1, 1, 0, "R7 long clamp");
        run_pkt(0, 8'h77, 8'd0, 8'd255, 1, 1, 0, 0, "R6 long N=257");
        run_pkt(3, 8'h88, 8'd255, 8'h00, 1, 1, 0, 0, "R5 short N=1");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule